// File: doc/BRIEF.md
# CAN Frame Header Decoder

This block sits behind a bit-level receiver that has already removed stuff bits. Each received bit arrives on `bit_val` together with a one-cycle qualifier `bit_vld`. Cycles with the qualifier low carry no bit. While idle, the decoder waits for a dominant start bit. It then walks the arbitration and control fields and assembles the identifier. The bit after the base identifier is held until the format bit that follows it shows whether the frame is standard or extended. After that the decoder counts the data field as set by the length code.

The results are presented as registered outputs. A one-cycle header pulse marks a new identifier, format flag, remote flag and length code, and these values are held until the next header. Each completed data byte comes with its own pulse. A frame-done pulse marks the last bit of the frame's data. A malformed extended header raises a one-cycle error pulse and sends the block back to idle. Stuff-bit removal, CRC, acknowledge, end-of-frame and bit timing are handled elsewhere.

Top module: `can_hdr_decoder`

## Requirements
- R1: While idle, a sample qualified by `bit_vld` with value 1, and any cycle with `bit_vld` low, leave the block idle. A qualified 0 starts a frame.
- R2: In a standard frame, the 11 identifier bits arrive MSB first after the start bit. `id_out` then carries them in bits 10:0 with zeros above, `ext_fmt` is 0, and `rtr` is the bit after the identifier. The next bit is the format bit, which is 0 here, followed by one reserved bit.
- R3: When the format bit is 1, the next 18 bits, MSB first, extend the identifier. `id_out` is then {base[10:0], extension[17:0]} and `ext_fmt` is 1. `rtr` is the bit after the extension, and the two reserved bits after it are ignored.
- R4: `hdr_vld` is high for exactly the one cycle after the clock edge that takes the fourth length-code bit. In that same cycle `id_out`, `ext_fmt`, `rtr` and `dlc` take their new values, and they hold them until the next `hdr_vld`. All of them read 0 after reset.
- R5: Data bits are packed MSB first into bytes. `byte_vld` pulses for one cycle after the edge that takes each byte's eighth bit, with the byte on `data_byte`.
- R6: The length code is received MSB first and shown unchanged on `dlc`. A code above 8 produces exactly 8 data bytes.
- R7: When `rtr` is 1 or the length code is 0, no data bits are consumed, and `frame_done` pulses in the same cycle as `hdr_vld`.
- R8: `frame_done` pulses in the same cycle as the `byte_vld` of the last data byte, and the block is idle again from the next qualified bit.
- R9: In an extended frame, a 0 in the bit before the format bit gives a one-cycle `fmt_err` pulse after the format bit's edge. There is then no `hdr_vld`, and the block is idle again.
- R10: Cycles with `bit_vld` low inside a frame change neither the field position nor any result, whatever `bit_val` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_vld | input | 1 | Qualifier: `bit_val` holds a received bit this cycle |
| bit_val | input | 1 | Destuffed bit value (0 dominant) |
| id_out | output | 29 | Assembled identifier |
| ext_fmt | output | 1 | 1 for extended-format frame |
| rtr | output | 1 | Remote-request flag |
| dlc | output | 4 | Received length code |
| hdr_vld | output | 1 | Header result pulse |
| data_byte | output | 8 | Last completed data byte |
| byte_vld | output | 1 | Data byte pulse |
| frame_done | output | 1 | Last data bit taken (or header only) |
| fmt_err | output | 1 | Extended header with dominant substitute bit |

## Verification
The bench targets the mid-header branch. If the held bit after the base identifier were mis-assigned, standard frames would report the wrong remote flag, and extended frames would either lose the extension bits or place them wrongly in the identifier. A length code above 8 checks the clamp: without it the block would swallow extra bits and the later frame would misalign. Remote and zero-length frames show whether the data count is skipped. A dominant substitute bit shows whether the block returns to idle rather than treating the rest of the header as valid. Gaps with a toggling `bit_val` inside frames, and recessive bits while idle, expose any path that moves on without a qualified bit.

// File: rtl/can_hdr_pkg.sv
// Shared types for the frame header decoder: the field-position state and
// the strobe bundle the sequencer hands to the field datapath.
package can_hdr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,   // waiting for a dominant start bit
        ST_BASE,   // base identifier bits
        ST_HOLD,   // bit after base id: remote flag or substitute bit
        ST_FMT,    // format bit decides standard or extended
        ST_EXT,    // identifier extension bits
        ST_XRTR,   // remote flag of an extended frame
        ST_RSV1,   // first reserved bit (extended only)
        ST_RSV0,   // last reserved bit
        ST_LEN,    // length code bits
        ST_DATA    // data field bits
    } hdr_state_e;

    typedef struct packed {
        logic sof;        // frame start: clear assembly registers
        logic id_shift;   // shift one identifier bit
        logic rtr_load;   // load remote flag with rtr_bit
        logic rtr_bit;
        logic ext_set;    // frame is extended
        logic dlc_shift;  // shift one length bit
        logic data_shift; // shift one data bit
        logic hdr_done;   // header complete on this bit
        logic byte_done;  // data byte complete on this bit
        logic frame_end;  // frame complete on this bit
        logic fmt_bad;    // malformed extended header
    } hdr_ctl_t;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/can_hdr_seq.sv
// Field sequencer. Tracks the position within the frame header and data
// field, one step per qualified bit, and emits strobes for the datapath.
// Assumes bits are already destuffed and bit_vld is a one-cycle qualifier.
module can_hdr_seq
    import can_hdr_pkg::*;
#(
    parameter int BASE_W    = 11,
    parameter int EXT_W     = 18,
    parameter int DLC_W     = 4,
    parameter int MAX_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_val,
    input  logic             rtr_q,
    input  logic [DLC_W-1:0] dlc_now,
    output hdr_ctl_t         ctl
);
    localparam int DBITS = MAX_BYTES * BYTE_W;
    localparam int CMAX  = (DBITS > EXT_W) ? DBITS : EXT_W;
    localparam int CNT_W = $clog2(CMAX + 1);

    hdr_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [CNT_W-1:0] tgt, tgt_nx;
    logic             hold_q, hold_nx;
    logic [CNT_W-1:0] nbytes;

    // Clamp the length code to the largest byte count.
    always_comb begin
        if (CNT_W'(dlc_now) > CNT_W'(MAX_BYTES)) nbytes = CNT_W'(MAX_BYTES);
        else                                     nbytes = CNT_W'(dlc_now);
    end

    // Next position and strobes for the current qualified bit.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        tgt_nx   = tgt;
        hold_nx  = hold_q;
        ctl      = '0;
        if (bit_vld) begin
            case (state)
                ST_IDLE: if (!bit_val) begin
                    ctl.sof  = 1'b1;
                    cnt_nx   = '0;
                    state_nx = ST_BASE;
                end
                ST_BASE: begin
                    ctl.id_shift = 1'b1;
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CNT_W'(BASE_W - 1)) state_nx = ST_HOLD;
                end
                ST_HOLD: begin
                    hold_nx  = bit_val;
                    state_nx = ST_FMT;
                end
                ST_FMT: begin
                    if (!bit_val) begin
                        ctl.rtr_load = 1'b1;
                        ctl.rtr_bit  = hold_q;
                        state_nx     = ST_RSV0;
                    end else if (!hold_q) begin
                        ctl.fmt_bad = 1'b1;
                        state_nx    = ST_IDLE;
                    end else begin
                        ctl.ext_set = 1'b1;
                        cnt_nx      = '0;
                        state_nx    = ST_EXT;
                    end
                end
                ST_EXT: begin
                    ctl.id_shift = 1'b1;
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CNT_W'(EXT_W - 1)) state_nx = ST_XRTR;
                end
                ST_XRTR: begin
                    ctl.rtr_load = 1'b1;
                    ctl.rtr_bit  = bit_val;
                    state_nx     = ST_RSV1;
                end
                ST_RSV1: state_nx = ST_RSV0;
                ST_RSV0: begin
                    cnt_nx   = '0;
                    state_nx = ST_LEN;
                end
                ST_LEN: begin
                    ctl.dlc_shift = 1'b1;
                    cnt_nx = cnt + 1'b1;
                    if (cnt == CNT_W'(DLC_W - 1)) begin
                        ctl.hdr_done = 1'b1;
                        cnt_nx = '0;
                        tgt_nx = nbytes << 3;
                        if (rtr_q || nbytes == '0) begin
                            ctl.frame_end = 1'b1;
                            state_nx      = ST_IDLE;
                        end else begin
                            state_nx = ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    ctl.data_shift = 1'b1;
                    cnt_nx = cnt + 1'b1;
                    if (cnt[2:0] == 3'b111) ctl.byte_done = 1'b1;
                    if (cnt == tgt - 1'b1) begin
                        ctl.frame_end = 1'b1;
                        state_nx      = ST_IDLE;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            tgt    <= '0;
            hold_q <= 1'b0;
        end else begin
            state  <= state_nx;
            cnt    <= cnt_nx;
            tgt    <= tgt_nx;
            hold_q <= hold_nx;
        end
    end

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && (!bit_vld || bit_val)) |=> state == ST_IDLE);

    // R10
    gap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> ($stable(state) && $stable(cnt)));

    // R6
    data_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA) |-> (cnt < CNT_W'(DBITS) && tgt <= CNT_W'(DBITS)));

endmodule

// File: rtl/can_hdr_fields.sv
// Field datapath. Assembles identifier, remote flag, length code and data
// bytes under sequencer strobes and registers all block outputs.
// Assumes at most one strobe group per cycle, driven by can_hdr_seq.
module can_hdr_fields
    import can_hdr_pkg::*;
#(
    parameter int BASE_W = 11,
    parameter int EXT_W  = 18,
    parameter int DLC_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_val,
    input  hdr_ctl_t                ctl,
    output logic                    rtr_q,
    output logic [DLC_W-1:0]        dlc_now,
    output logic [BASE_W+EXT_W-1:0] id_out,
    output logic                    ext_fmt,
    output logic                    rtr,
    output logic [DLC_W-1:0]        dlc,
    output logic                    hdr_vld,
    output logic [BYTE_W-1:0]       data_byte,
    output logic                    byte_vld,
    output logic                    frame_done,
    output logic                    fmt_err
);
    localparam int ID_W = BASE_W + EXT_W;

    logic [ID_W-1:0]   id_sr;
    logic [DLC_W-2:0]  dlc_sr;
    logic [BYTE_W-2:0] dat_sr;
    logic              ext_q;
    logic              past_ok;

    assign dlc_now = {dlc_sr, bit_val};

    // Assembly shift registers, cleared at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_sr  <= '0;
            dlc_sr <= '0;
            dat_sr <= '0;
            ext_q  <= 1'b0;
            rtr_q  <= 1'b0;
        end else if (ctl.sof) begin
            id_sr  <= '0;
            dlc_sr <= '0;
            ext_q  <= 1'b0;
            rtr_q  <= 1'b0;
        end else begin
            if (ctl.id_shift)   id_sr  <= {id_sr[ID_W-2:0], bit_val};
            if (ctl.dlc_shift)  dlc_sr <= dlc_now[DLC_W-2:0];
            if (ctl.data_shift) dat_sr <= {dat_sr[BYTE_W-3:0], bit_val};
            if (ctl.ext_set)    ext_q  <= 1'b1;
            if (ctl.rtr_load)   rtr_q  <= ctl.rtr_bit;
        end
    end

    // Held header results and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_out     <= '0;
            ext_fmt    <= 1'b0;
            rtr        <= 1'b0;
            dlc        <= '0;
            data_byte  <= '0;
            hdr_vld    <= 1'b0;
            byte_vld   <= 1'b0;
            frame_done <= 1'b0;
            fmt_err    <= 1'b0;
        end else begin
            hdr_vld    <= ctl.hdr_done;
            byte_vld   <= ctl.byte_done;
            frame_done <= ctl.frame_end;
            fmt_err    <= ctl.fmt_bad;
            if (ctl.hdr_done) begin
                id_out  <= id_sr;
                ext_fmt <= ext_q;
                rtr     <= rtr_q;
                dlc     <= dlc_now;
            end
            if (ctl.byte_done) data_byte <= {dat_sr, bit_val};
        end
    end

    // Marks cycles with a defined previous output value.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R4
    hdr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> !hdr_vld);

    // R4
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !hdr_vld) |-> ($stable(id_out) && $stable(dlc) && $stable(rtr)));

    // R8
    done_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (byte_vld || hdr_vld));

    // R9
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !(hdr_vld || byte_vld || frame_done));

endmodule

// File: rtl/can_hdr_decoder.sv
// Top of the frame header decoder: joins the field sequencer and the field
// datapath. Assumes destuffed input bits, one per bit_vld cycle.
module can_hdr_decoder
    import can_hdr_pkg::*;
#(
    parameter int BASE_W    = 11,
    parameter int EXT_W     = 18,
    parameter int DLC_W     = 4,
    parameter int MAX_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_vld,
    input  logic                    bit_val,
    output logic [BASE_W+EXT_W-1:0] id_out,
    output logic                    ext_fmt,
    output logic                    rtr,
    output logic [DLC_W-1:0]        dlc,
    output logic                    hdr_vld,
    output logic [BYTE_W-1:0]       data_byte,
    output logic                    byte_vld,
    output logic                    frame_done,
    output logic                    fmt_err
);
    hdr_ctl_t         ctl;
    logic             rtr_q;
    logic [DLC_W-1:0] dlc_now;

    can_hdr_seq #(
        .BASE_W(BASE_W), .EXT_W(EXT_W), .DLC_W(DLC_W), .MAX_BYTES(MAX_BYTES)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .rtr_q(rtr_q), .dlc_now(dlc_now), .ctl(ctl)
    );

    can_hdr_fields #(
        .BASE_W(BASE_W), .EXT_W(EXT_W), .DLC_W(DLC_W)
    ) u_fields (
        .clk(clk), .rst_n(rst_n), .bit_val(bit_val), .ctl(ctl),
        .rtr_q(rtr_q), .dlc_now(dlc_now),
        .id_out(id_out), .ext_fmt(ext_fmt), .rtr(rtr), .dlc(dlc),
        .hdr_vld(hdr_vld), .data_byte(data_byte), .byte_vld(byte_vld),
        .frame_done(frame_done), .fmt_err(fmt_err)
    );

endmodule

// File: tb/can_hdr_decoder_tb.sv
// Bench: frames are built as bit queues from their field values; expected
// pulses and held results are derived per bit and compared every cycle.
module can_hdr_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_val = 1'b1;
    logic [28:0] id_out;
    logic        ext_fmt, rtr, hdr_vld, byte_vld, frame_done, fmt_err;
    logic [3:0]  dlc;
    logic [7:0]  data_byte;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    int cycles = 0;

    // pending expectations for the next sample point
    bit          p_hdr = 0, p_byte = 0, p_done = 0, p_err = 0;
    logic [7:0]  p_bval = '0;
    logic [28:0] e_id = '0;
    bit          e_ext = 0, e_rtr = 0;
    logic [3:0]  e_dlc = '0;
    // expectations for the bit being driven now
    bit          n_hdr, n_byte, n_done, n_err;
    logic [7:0]  n_bval;
    // current frame's header values
    logic [28:0] f_id;
    bit          f_ext, f_rtr;
    logic [3:0]  f_dlc;
    string       tag = "R4";

    can_hdr_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
        .id_out(id_out), .ext_fmt(ext_fmt), .rtr(rtr), .dlc(dlc),
        .hdr_vld(hdr_vld), .data_byte(data_byte), .byte_vld(byte_vld),
        .frame_done(frame_done), .fmt_err(fmt_err)
    );

    always #4 clk = ~clk;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs against pending expectations, then drive the next input.
    task automatic tick(input logic v, input logic b);
        @(negedge clk);
        chk("R4", {tag, " hdr_vld"}, 32'(hdr_vld), 32'(p_hdr));
        chk("R5", {tag, " byte_vld"}, 32'(byte_vld), 32'(p_byte));
        chk("R8", {tag, " frame_done"}, 32'(frame_done), 32'(p_done));
        chk("R9", {tag, " fmt_err"}, 32'(fmt_err), 32'(p_err));
        chk(e_ext ? "R3" : "R2", {tag, " id_out"}, 32'(id_out), 32'(e_id));
        chk("R4", {tag, " ext_fmt"}, 32'(ext_fmt), 32'(e_ext));
        chk("R4", {tag, " rtr"}, 32'(rtr), 32'(e_rtr));
        chk("R6", {tag, " dlc"}, 32'(dlc), 32'(e_dlc));
        if (p_byte) chk("R5", {tag, " data_byte"}, 32'(data_byte), 32'(p_bval));
        bit_vld = v;
        bit_val = b;
        p_hdr  = v & n_hdr;
        p_byte = v & n_byte;
        p_done = v & n_done;
        p_err  = v & n_err;
        p_bval = n_bval;
        if (v && n_hdr) begin
            e_id = f_id; e_ext = f_ext; e_rtr = f_rtr; e_dlc = f_dlc;
        end
        n_hdr = 0; n_byte = 0; n_done = 0; n_err = 0; n_bval = '0;
    endtask

    function automatic logic [7:0] byte_of(logic [28:0] id, int j);
        return 8'(id >> j) ^ 8'(j * 59) ^ 8'h5A;
    endfunction

    task automatic run_frame(string t, bit ext, logic [28:0] id, bit srr,
                             bit rb, logic [3:0] dl, int gap);
        bit q[$];
        int hdr_i = -1, err_i = -1, nb = 0, last_i = -1;
        tag = t;
        q.push_back(1'b0);
        for (int k = 10; k >= 0; k--) q.push_back(ext ? id[k+18] : id[k]);
        if (ext) begin
            q.push_back(srr);
            q.push_back(1'b1);
            if (!srr) err_i = q.size() - 1;
            else begin
                for (int k = 17; k >= 0; k--) q.push_back(id[k]);
                q.push_back(rb); q.push_back(1'b0); q.push_back(1'b0);
            end
        end else begin
            q.push_back(rb); q.push_back(1'b0); q.push_back(1'b0);
        end
        if (err_i < 0) begin
            for (int k = 3; k >= 0; k--) q.push_back(dl[k]);
            hdr_i = q.size() - 1;
            nb = rb ? 0 : ((dl > 8) ? 8 : int'(dl));
            for (int j = 0; j < nb; j++)
                for (int k = 7; k >= 0; k--) q.push_back(byte_of(id, j)[k]);
            last_i = q.size() - 1;
        end
        q.push_back(1'b1); q.push_back(1'b1);
        f_id = ext ? id : {18'b0, id[10:0]};
        f_ext = ext; f_rtr = rb; f_dlc = dl;
        for (int i = 0; i < q.size(); i++) begin
            for (int g = 0; g < gap; g++) begin
                tick(1'b0, logic'(g[0]));
            end
            if (i == hdr_i) n_hdr = 1;
            if (i == err_i) n_err = 1;
            if (i == last_i) n_done = 1;
            if (hdr_i >= 0 && i > hdr_i && i <= last_i && ((i - hdr_i) % 8) == 0) begin
                n_byte = 1;
                n_bval = byte_of(id, (i - hdr_i) / 8 - 1);
            end
            tick(1'b1, q[i]);
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !finished) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 190000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        n_hdr = 0; n_byte = 0; n_done = 0; n_err = 0; n_bval = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset state (R4): all results zero
        tick(1'b0, 1'b1);
        // R1: recessive qualified bits and unqualified dominant bits while idle
        tag = "R1";
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b1);
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0);
        // R2: standard frame, two bytes
        run_frame("R2", 1'b0, 29'h000005A3, 1'b1, 1'b0, 4'd2, 0);
        // R3 and R10: extended frame with gaps
        run_frame("R3", 1'b1, 29'h1ABCDE12, 1'b1, 1'b0, 4'd3, 2);
        // R6: length above 8 gives eight bytes
        run_frame("R6", 1'b0, 29'h00000321, 1'b1, 1'b0, 4'd12, 0);
        // R7: remote frame skips data
        run_frame("R7", 1'b0, 29'h0000047F, 1'b1, 1'b1, 4'd5, 1);
        // R7: extended zero-length frame
        run_frame("R7", 1'b1, 29'h0F0F0F0F, 1'b1, 1'b0, 4'd0, 0);
        // R9: dominant substitute bit in extended header
        run_frame("R9", 1'b1, 29'h15555555, 1'b0, 1'b0, 4'd4, 0);
        // R8: back to idle, full frame after error
        run_frame("R8", 1'b0, 29'h00000001, 1'b1, 1'b0, 4'd8, 0);
        // R10: extended remote frame with long gaps
        run_frame("R10", 1'b1, 29'h00000000, 1'b1, 1'b1, 4'd15, 3);
        // R5: standard frame, one byte
        run_frame("R5", 1'b0, 29'h000007FF, 1'b1, 1'b0, 4'd1, 1);
        tag = "R1";
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule